// File: doc/BRIEF.md
# Oversampled RC Subframe Deframer

This block sits behind the demodulator of a radio-control receiver. It takes the recovered line signal, sampled five times per bit at a 6,400 bit/s line rate. It rebuilds the bit stream, hunts for a fixed 12-bit sync pattern and collects the 90-bit body that follows. It then checks two CRC-10 words and, if both match, updates eight proportional channel values, eight on/off switch bits and a failsafe flag. Together these are the sixteen channels of the link.

Subframes alternate between two channel groups. One part of each subframe carries absolute 10-bit values for one group. The other part carries small, exponentially coded steps for the other group, applied to the values held for those channels. Subframes follow one another with no gap, so sync hunting resumes as soon as the last check bit is in. The sample strobe `sample_en` comes from the surrounding logic at five times the bit rate. Each decoded result is presented one sample period after the final check bit is decided.

Top module: `rc_subframe_deframer`

## Requirements
- R1: Each bit spans five samples on `sample_en`. The sample phase restarts at 0 on every sample that differs from the one before. The bit value is the majority of the samples at phases 1, 2 and 3, decided at phase 3. A one-sample glitch on the first sample of each bit leaves the decoded data unchanged.
- R2: While hunting, the block compares the last 12 decided bits with 12'hF8B (first bit received is the MSB). On a match it collects the next 90 bits as nine 10-bit words, each sent MSB first. Hunting restarts at once after the 90th bit, so back-to-back subframes are all decoded.
- R3: In word 0, bit 9 is the odd flag, bit 8 is the failsafe flag and bits 7:0 are the switches. The `switches` and `failsafe` outputs take these values on every accepted subframe.
- R4: Words 1 to 4 are absolute values. When odd=0 they load channels 0 to 3; when odd=1 they load channels 4 to 7. Channel k appears on `chan_values[10k+9:10k]`. All channels are 0 after reset.
- R5: Words 5 and 6 each hold two 5-bit step codes, the upper code first, for four consecutive channels. These are channels 4 to 7 when odd=0 and channels 0 to 3 when odd=1. In each code, bit 4 is the sign (1 = subtract), e = bits 3:2 and f = bits 1:0. The magnitude is ((4+f) << e) - 4. The result is clamped to 0..1023.
- R6: A step is ignored for any channel that has not been loaded with an absolute value since reset. Such a channel keeps its value.
- R7: Word 7 must equal the CRC-10 (polynomial 0x233, zero initial value, MSB-first) of words 0 to 6 in order. Word 8 must equal the same CRC over words 6 down to 0. Otherwise all outputs hold and `crc_err` pulses for one clock.
- R8: `frame_valid` or `crc_err` pulses for exactly one clock. The pulse starts on the first `sample_en` after the last check bit is decided, and the outputs update on that same edge. No pulse occurs at any other time.
- R9: `link_lost` rises on the 8th consecutive rejected subframe. It stays high through further rejects and clears on the next accepted subframe.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sample_en | input | 1 | One-clock strobe marking each line sample, five per bit |
| rx_in | input | 1 | Demodulated line level, valid when `sample_en` is high |
| chan_values | output | 80 | Eight 10-bit proportional channel values, channel 0 in the low bits |
| switches | output | 8 | On/off switch channels from the last accepted subframe |
| failsafe | output | 1 | Failsafe flag from the last accepted subframe |
| frame_valid | output | 1 | One-clock pulse when a subframe is accepted |
| crc_err | output | 1 | One-clock pulse when a subframe fails either check |
| link_lost | output | 1 | High after eight rejected subframes in a row |

## Verification
The hardest states to reach from the ports are those that depend on a run of history. One is a step code arriving for a channel that has never held an absolute value. Another is the eighth rejection in a row. The stimulus reaches the first by opening with an even subframe, whose steps target channels 4 to 7 before any odd subframe has loaded them. It reaches the second with a directed burst of subframes in which one random bit is flipped, checking `link_lost` after the seventh and eighth, and then with an accepted subframe that clears it. It also drives a subframe in which the first sample of every bit is inverted, to exercise phase realignment. Saturation at both ends of the range comes from directed absolute values of 1020 and 3 followed by the largest step in each direction.

// File: rtl/rc_subframe_deframer.sv
module rc_subframe_deframer #(
  parameter int OSR = 5,
  parameter int PRE_W = 12,
  parameter logic [PRE_W-1:0] PREAMBLE = 12'hF8B,
  parameter int LOST_LIMIT = 8
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        sample_en,
  input  logic        rx_in,
  output logic [79:0] chan_values,
  output logic [7:0]  switches,
  output logic        failsafe,
  output logic        frame_valid,
  output logic        crc_err,
  output logic        link_lost
);
  localparam int WW = 10;
  localparam int NW = 9;
  localparam int FB = WW * NW;
  localparam int NCH = 8;
  localparam int PH_W = $clog2(OSR);
  localparam int CNT_W = $clog2(FB);
  localparam int LC_W = $clog2(LOST_LIMIT + 1);
  localparam logic [PH_W-1:0] PH_LAST = PH_W'(OSR - 1);
  localparam logic [PH_W-1:0] PH_DEC = PH_W'(OSR - 2);
  localparam logic [PH_W:0] VOTE_N = (PH_W+1)'(OSR - 2);
  localparam logic [CNT_W-1:0] BIT_LAST = CNT_W'(FB - 1);
  localparam logic [LC_W-1:0] LC_MAX = LC_W'(LOST_LIMIT);
  localparam logic [WW-1:0] POLY = 10'h233;

  // bit recovery
  logic rx_q, bit_v, bit_stb;
  logic [PH_W-1:0] ph, ph_n, vc, vote_sum;

  assign ph_n = (rx_in != rx_q) ? '0 : (ph == PH_LAST) ? '0 : ph + 1'b1;
  assign vote_sum = vc + PH_W'(rx_in);
  assign bit_v = {vote_sum, 1'b0} > VOTE_N;
  assign bit_stb = sample_en && (ph_n == PH_DEC);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rx_q <= 1'b0;
      ph <= '0;
      vc <= '0;
    end else if (sample_en) begin
      rx_q <= rx_in;
      ph <= ph_n;
      vc <= (ph_n == '0) ? '0 : vote_sum;
    end
  end

  // framing
  logic collecting, done, commit;
  logic [PRE_W-1:0] hist, hist_n;
  logic [FB-1:0] fsr;
  logic [CNT_W-1:0] bcnt;

  assign hist_n = {hist[PRE_W-2:0], bit_v};
  assign commit = sample_en && done;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      collecting <= 1'b0;
      done <= 1'b0;
      hist <= '0;
      fsr <= '0;
      bcnt <= '0;
    end else begin
      if (commit) done <= 1'b0;
      if (bit_stb) begin
        if (!collecting) begin
          hist <= hist_n;
          if (hist_n == PREAMBLE) begin
            collecting <= 1'b1;
            bcnt <= '0;
          end
        end else begin
          fsr <= {fsr[FB-2:0], bit_v};
          if (bcnt == BIT_LAST) begin
            collecting <= 1'b0;
            done <= 1'b1;
            hist <= '0;
          end else begin
            bcnt <= bcnt + 1'b1;
          end
        end
      end
    end
  end

  // checking
  function automatic logic [WW-1:0] crc_word(input logic [WW-1:0] c, input logic [WW-1:0] d);
    logic [WW-1:0] r;
    r = c;
    for (int b = WW - 1; b >= 0; b--)
      r = {r[WW-2:0], 1'b0} ^ ((r[WW-1] ^ d[b]) ? POLY : '0);
    return r;
  endfunction

  logic [WW-1:0] wd [NW];
  logic [WW-1:0] crc_f, crc_r;
  logic ok, odd;

  always_comb begin
    for (int k = 0; k < NW; k++) wd[k] = fsr[FB-1-WW*k -: WW];
    crc_f = '0;
    crc_r = '0;
    for (int k = 0; k < 7; k++) begin
      crc_f = crc_word(crc_f, wd[k]);
      crc_r = crc_word(crc_r, wd[6-k]);
    end
  end

  assign ok = (crc_f == wd[7]) && (crc_r == wd[8]);
  assign odd = wd[0][9];

  // channel reconstruction
  function automatic logic [WW-1:0] apply_delta(input logic [WW-1:0] v, input logic [4:0] c);
    logic [WW+1:0] mag, wide;
    mag = ({{(WW-1){1'b0}}, 1'b1, c[1:0]} << c[3:2]) - (WW+2)'(4);
    wide = {2'b00, v};
    if (c[4]) return (mag > wide) ? '0 : WW'(wide - mag);
    wide = wide + mag;
    return (wide > (WW+2)'((1 << WW) - 1)) ? '1 : wide[WW-1:0];
  endfunction

  for (genvar i = 0; i < NCH; i++) begin : g_ch
    localparam int J = i % 4;
    localparam logic GRP = (i >= 4);
    logic [WW-1:0] val;
    logic have;
    logic [4:0] code;

    assign code = (J % 2 == 0) ? wd[5 + J/2][9:5] : wd[5 + J/2][4:0];
    assign chan_values[WW*i +: WW] = val;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        val <= '0;
        have <= 1'b0;
      end else if (commit && ok) begin
        if (odd == GRP) begin
          val <= wd[1 + J];
          have <= 1'b1;
        end else if (have) begin
          val <= apply_delta(val, code);
        end
      end
    end
  end

  // results
  logic [LC_W-1:0] lc;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      switches <= '0;
      failsafe <= 1'b0;
      frame_valid <= 1'b0;
      crc_err <= 1'b0;
      link_lost <= 1'b0;
      lc <= '0;
    end else begin
      frame_valid <= 1'b0;
      crc_err <= 1'b0;
      if (commit) begin
        if (ok) begin
          frame_valid <= 1'b1;
          switches <= wd[0][7:0];
          failsafe <= wd[0][8];
          lc <= '0;
          link_lost <= 1'b0;
        end else begin
          crc_err <= 1'b1;
          if (lc != LC_MAX) lc <= lc + 1'b1;
          if (lc >= LC_MAX - 1'b1) link_lost <= 1'b1;
        end
      end
    end
  end

  assert_strobe_excl_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !(frame_valid && crc_err));
  assert_hold_on_error_R7: assert property (@(posedge clk) disable iff (!rst_n)
    crc_err |-> (chan_values == $past(chan_values)) && (switches == $past(switches))
                && (failsafe == $past(failsafe)));
  assert_strobe_on_sample_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_valid || crc_err) |-> $past(sample_en));
  assert_strobe_single_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_valid || crc_err) |=> !(frame_valid || crc_err));
  assert_lost_rise_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(link_lost) |-> crc_err);
  assert_lost_clear_R9: assert property (@(posedge clk) disable iff (!rst_n)
    frame_valid |-> !link_lost);
endmodule

// File: tb/rc_subframe_deframer_tb.sv
module rc_subframe_deframer_tb;
  logic clk = 1'b0;
  logic rst_n, sen, rx;
  logic [79:0] chan_values;
  logic [7:0] switches;
  logic failsafe, frame_valid, crc_err, link_lost;

  always #4 clk = ~clk;

  rc_subframe_deframer u_dut (
    .clk(clk), .rst_n(rst_n), .sample_en(sen), .rx_in(rx),
    .chan_values(chan_values), .switches(switches), .failsafe(failsafe),
    .frame_valid(frame_valid), .crc_err(crc_err), .link_lost(link_lost)
  );

  int n_chk = 0, n_fail = 0;
  int fv_cnt, er_cnt;
  bit fv_now, er_now;
  logic [9:0] fw [9];
  int exp_ch [8];
  bit exp_have [8];
  logic [7:0] exp_sw;
  bit exp_fs, exp_lost;
  int rej;

  task automatic check(input bit ok, input string what, input logic [79:0] act, input logic [79:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", what, act, exp);
    end
  endtask

  task automatic tick(input logic v);
    @(negedge clk);
    rx = v;
    sen = 1'b1;
    @(posedge clk);
    #1;
    fv_now = frame_valid;
    er_now = crc_err;
    if (fv_now) fv_cnt++;
    if (er_now) er_cnt++;
    @(negedge clk);
    sen = 1'b0;
    repeat (2) @(negedge clk);
  endtask

  function automatic logic [9:0] bcrc(input logic [69:0] msg);
    logic [9:0] r;
    logic top;
    r = '0;
    for (int i = 79; i >= 0; i--) begin
      top = r[9];
      r = {r[8:0], (i >= 10) ? msg[i-10] : 1'b0};
      if (top) r = r ^ 10'h233;
    end
    return r;
  endfunction

  function automatic int bstep(input int v, input logic [4:0] c);
    int m, r;
    m = (4 + int'(c[1:0])) * (1 << c[3:2]) - 4;
    r = c[4] ? v - m : v + m;
    if (r < 0) r = 0;
    if (r > 1023) r = 1023;
    return r;
  endfunction

  task automatic build(input bit odd, input bit fs, input logic [7:0] sw,
                       input logic [39:0] ab, input logic [19:0] dc);
    fw[0] = {odd, fs, sw};
    for (int k = 0; k < 4; k++) fw[1+k] = ab[39-10*k -: 10];
    fw[5] = dc[19:10];
    fw[6] = dc[9:0];
    fw[7] = bcrc({fw[0], fw[1], fw[2], fw[3], fw[4], fw[5], fw[6]});
    fw[8] = bcrc({fw[6], fw[5], fw[4], fw[3], fw[2], fw[1], fw[0]});
  endtask

  task automatic send_frame(input string tag, input bit corrupt, input bit glitch, input int gap);
    logic [101:0] bits;
    logic [79:0] ev;
    bit odd;
    int fi;
    for (int g = 0; g < gap; g++) tick(1'b0);
    bits = {12'hF8B, fw[0], fw[1], fw[2], fw[3], fw[4], fw[5], fw[6], fw[7], fw[8]};
    if (corrupt) begin
      fi = $urandom_range(89, 0);
      bits[fi] = ~bits[fi];
    end
    fv_cnt = 0;
    er_cnt = 0;
    for (int b = 101; b >= 0; b--)
      for (int s = 0; s < 5; s++) tick((glitch && s == 0) ? ~bits[b] : bits[b]);
    if (glitch) tick(bits[0]);
    odd = fw[0][9];
    if (!corrupt) begin
      for (int i = 0; i < 8; i++) begin
        if ((i >= 4) == odd) begin
          exp_ch[i] = int'(fw[1 + i%4]);
          exp_have[i] = 1'b1;
        end else if (exp_have[i]) begin
          exp_ch[i] = bstep(exp_ch[i], ((i%4)%2 == 0) ? fw[5 + (i%4)/2][9:5] : fw[5 + (i%4)/2][4:0]);
        end
      end
      exp_sw = fw[0][7:0];
      exp_fs = fw[0][8];
      rej = 0;
      exp_lost = 1'b0;
      check(fv_cnt == 1 && fv_now && er_cnt == 0, {tag, " R8 accept strobe on final sample"},
            80'({fv_cnt[7:0], 3'b0, fv_now, er_cnt[7:0]}), 80'h01_1_00);
    end else begin
      rej++;
      if (rej >= 8) exp_lost = 1'b1;
      check(er_cnt == 1 && er_now && fv_cnt == 0, {tag, " R7 R8 reject strobe"},
            80'({er_cnt[7:0], 3'b0, er_now, fv_cnt[7:0]}), 80'h01_1_00);
    end
    for (int i = 0; i < 8; i++) ev[10*i +: 10] = 10'(exp_ch[i]);
    check(chan_values == ev, {tag, " R4 R5 R6 channel values"}, chan_values, ev);
    check(switches == exp_sw && failsafe == exp_fs, {tag, " R3 switches/failsafe"},
          80'({failsafe, switches}), 80'({exp_fs, exp_sw}));
    check(link_lost == exp_lost, {tag, " R9 link_lost"}, 80'(link_lost), 80'(exp_lost));
  endtask

  task automatic random_frame(input string tag, input bit corrupt, input bit glitch, input int gap);
    logic [39:0] ab;
    logic [19:0] dc;
    for (int k = 0; k < 4; k++) ab[10*k +: 10] = 10'($urandom_range(1023, 0));
    dc = 20'($urandom);
    build(1'($urandom), 1'($urandom), 8'($urandom), ab, dc);
    send_frame(tag, corrupt, glitch, gap);
  endtask

  initial begin
    repeat (195000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual hung expected finished");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    int seed;
    seed = $urandom(32'd20240611);
    rst_n = 1'b0;
    sen = 1'b0;
    rx = 1'b0;
    for (int i = 0; i < 8; i++) begin
      exp_ch[i] = 0;
      exp_have[i] = 1'b0;
    end
    exp_sw = '0;
    exp_fs = 1'b0;
    exp_lost = 1'b0;
    rej = 0;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    check(chan_values == '0, "R4 reset channels", chan_values, '0);
    check(switches == '0 && failsafe == 1'b0, "R3 reset switches", 80'({failsafe, switches}), '0);
    check(link_lost == 1'b0 && frame_valid == 1'b0 && crc_err == 1'b0, "R9 reset flags",
          80'({link_lost, frame_valid, crc_err}), '0);

    // even subframe: steps aimed at channels 4..7 that were never loaded
    build(1'b0, 1'b0, 8'hA5, {10'd100, 10'd200, 10'd300, 10'd400}, {5'h0F, 5'h1F, 5'h05, 5'h11});
    send_frame("R6 unloaded", 1'b0, 1'b0, 3);
    // odd subframe: load 4..7, steps on 0..3
    build(1'b1, 1'b1, 8'h3C, {10'd1020, 10'd3, 10'd500, 10'd0}, {5'h03, 5'h13, 5'h00, 5'h0F});
    send_frame("R4 odd load", 1'b0, 1'b0, 0);
    // even subframe: saturation both ways on 4..7
    build(1'b0, 1'b0, 8'h0F, {10'd11, 10'd22, 10'd33, 10'd44}, {5'h0F, 5'h1F, 5'h00, 5'h11});
    send_frame("R5 saturate", 1'b0, 1'b0, 0);
    // first sample of every bit inverted
    random_frame("R1 glitch", 1'b0, 1'b1, 0);
    random_frame("R1 after glitch", 1'b0, 1'b0, 2);
    // run of rejects
    for (int k = 0; k < 9; k++) random_frame("R9 reject run", 1'b1, 1'b0, 0);
    random_frame("R9 recover", 1'b0, 1'b0, 0);
    // back-to-back random traffic
    for (int k = 0; k < 32; k++)
      random_frame("R2 random", ($urandom_range(4, 0) == 0), ($urandom_range(7, 0) == 0),
                   ($urandom_range(2, 0) == 0) ? $urandom_range(6, 0) : 0);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule